// File: doc/BRIEF.md
# Three-Phase Dead-Time Gate Driver Stage

This block sits between a three-phase PWM generator and the gate drivers of an inverter bridge. Each phase arrives as a pair of raw requests, one for the high-side switch and one for the low-side switch. The block turns them into six registered gate-drive outputs. An output turns off as soon as its request drops. An output turns on only after the phase's dead-time counter has counted the programmed number of ticks since that phase's requests last changed. All three counters reload from one shared dead-time value. A tick is either every clock or every second clock, and dead-time insertion can be switched off.

The active level of the high-side outputs and of the low-side outputs is configured separately. A per-phase guard blocks both outputs of a phase if both settled requests are active together, and a sticky fault flag records that event. A hardware cutoff input (active low) acts only in motor-control mode with the output enable set. It forces all six outputs inactive and latches. Driving resumes only after the latch is cleared with `flag_clr` and the output enable has been taken low and high again. All pins are plain level signals, and the block has no valid/ready stream interface.

Top module: `dead_time_gen`

## Requirements
- R1: After reset every output sits at its inactive level, which is the inverse of its active-level select, and `fault` is 0.
- R2: With dead time enabled and `dt_div2`=0, an output whose request rises (together with the other side falling) shows its active level exactly `dt_value`+1 clock edges after the edge that first samples the change, and not earlier.
- R3: With dead time enabled and `dt_div2`=1, the same turn-on happens exactly 2*`dt_value`+1 edges after the edge that first samples the change.
- R4: With `dt_en`=0, an output follows its request at the edge that samples it, with no dead time.
- R5: An output goes inactive at the edge that samples its request low. An output is never active unless its request was high at the previous edge.
- R6: `act_hi_pos`=1 makes the high-side outputs active high and 0 makes them active low. `act_hi_neg` does the same for the low-side outputs, independently.
- R7: If both settled requests of a phase are active, both outputs of that phase are inactive. The two outputs of a phase are never active together.
- R8: `fault` rises at the edge where any phase has both settled requests active. It stays 1 until `flag_clr` is high at an edge with no such phase.
- R9: With `mc_mode`=1 and `out_enable`=1, `cutoff_n`=0 makes all six outputs inactive from the next edge on. With `mc_mode`=0, `cutoff_n` has no effect.
- R10: After a cutoff, the outputs stay inactive after `cutoff_n` returns high. They drive again only once `flag_clr` has been pulsed and `out_enable` has gone low then high, in either order.
- R11: The three phases time their dead times independently. A change on one phase does not disturb the outputs of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ph_hi | input | 3 | Raw high-side request per phase |
| ph_lo | input | 3 | Raw low-side request per phase |
| dt_value | input | 8 | Shared dead-time length in ticks |
| dt_div2 | input | 1 | 1: tick every second clock; 0: every clock |
| dt_en | input | 1 | Dead-time insertion enable |
| act_hi_pos | input | 1 | Active level of high-side outputs (1 = high) |
| act_hi_neg | input | 1 | Active level of low-side outputs (1 = high) |
| mc_mode | input | 1 | Motor-control mode; qualifies the cutoff |
| out_enable | input | 1 | Output enable; a rising edge arms driving |
| cutoff_n | input | 1 | Forced cutoff, active low |
| flag_clr | input | 1 | Clears the cutoff latch and the fault flag |
| drv_pos | output | 3 | High-side gate drives |
| drv_neg | output | 3 | Low-side gate drives |
| fault | output | 1 | Sticky concurrent-request flag |

## Verification
A counter stuck at a wrong value or reloaded at the wrong moment shows up at the next turn-on of that phase: the output becomes active one or more edges early or late. The bench probes the edge just before and the edge of the expected turn-on to catch this. A lost cutoff latch or arming flag lets the outputs drive at the first edge after `cutoff_n` returns or after `flag_clr`, and both of those edges are sampled. A guard that leaks shows both outputs of a phase active, and a fault flag that is not sticky drops within one cycle of the overlap ending. Both are caught at once by the checker and by the bench's hold checks.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int PHASES_DEF = 3;
  localparam int DT_W_DEF   = 8;

  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_LO   = 2'b01,
    REQ_HI   = 2'b10,
    REQ_BOTH = 2'b11
  } req_pair_e;
endpackage

// File: rtl/dtg_phase.sv
module dtg_phase #(
  parameter int DT_W = dtg_pkg::DT_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_hi,
  input  logic            req_lo,
  input  logic [DT_W-1:0] dt_val,
  input  logic            dt_en,
  input  logic            div2,
  input  logic            drive_ok,
  output logic            on_hi,
  output logic            on_lo,
  output logic            both_req
);
  import dtg_pkg::*;

  req_pair_e       prev_q;
  req_pair_e       cur;
  logic [DT_W-1:0] cnt_q;
  logic            tgl_q;
  logic            change;
  logic            settled;
  logic            hi_req;
  logic            lo_req;
  logic            tick;

  assign cur      = req_pair_e'({req_hi, req_lo});
  assign change   = (cur != prev_q);
  assign settled  = ~dt_en | ((cnt_q == '0) & ~change);
  assign hi_req   = req_hi & settled;
  assign lo_req   = req_lo & settled;
  assign both_req = hi_req & lo_req;
  assign tick     = ~div2 | tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= REQ_NONE;
      cnt_q  <= '0;
      tgl_q  <= 1'b0;
      on_hi  <= 1'b0;
      on_lo  <= 1'b0;
    end else begin
      prev_q <= cur;
      if (change) begin
        cnt_q <= dt_en ? dt_val : '0;
        tgl_q <= 1'b0;
      end else begin
        tgl_q <= ~tgl_q;
        if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
      on_hi <= hi_req & ~both_req & drive_ok;
      on_lo <= lo_req & ~both_req & drive_ok;
    end
  end
endmodule

// File: rtl/dtg_cutoff.sv
module dtg_cutoff (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_mode,
  input  logic out_enable,
  input  logic cutoff_n,
  input  logic flag_clr,
  output logic drive_ok
);
  logic trip;
  logic oe_q;
  logic armed_q;
  logic cut_q;

  assign trip     = mc_mode & out_enable & ~cutoff_n;
  assign drive_ok = out_enable & armed_q & ~cut_q & ~trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      armed_q <= 1'b0;
      cut_q   <= 1'b0;
    end else begin
      oe_q <= out_enable;
      if (trip)          cut_q <= 1'b1;
      else if (flag_clr) cut_q <= 1'b0;
      if (trip)                         armed_q <= 1'b0;
      else if (out_enable && !oe_q)     armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dead_time_gen.sv
module dead_time_gen #(
  parameter int N_PH = dtg_pkg::PHASES_DEF,
  parameter int DT_W = dtg_pkg::DT_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_PH-1:0] ph_hi,
  input  logic [N_PH-1:0] ph_lo,
  input  logic [DT_W-1:0] dt_value,
  input  logic            dt_div2,
  input  logic            dt_en,
  input  logic            act_hi_pos,
  input  logic            act_hi_neg,
  input  logic            mc_mode,
  input  logic            out_enable,
  input  logic            cutoff_n,
  input  logic            flag_clr,
  output logic [N_PH-1:0] drv_pos,
  output logic [N_PH-1:0] drv_neg,
  output logic            fault
);
  logic            drive_ok;
  logic [N_PH-1:0] on_hi;
  logic [N_PH-1:0] on_lo;
  logic [N_PH-1:0] both;

  dtg_cutoff u_cut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mc_mode    (mc_mode),
    .out_enable (out_enable),
    .cutoff_n   (cutoff_n),
    .flag_clr   (flag_clr),
    .drive_ok   (drive_ok)
  );

  for (genvar g = 0; g < N_PH; g++) begin : g_ph
    dtg_phase #(.DT_W(DT_W)) u_ph (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_hi   (ph_hi[g]),
      .req_lo   (ph_lo[g]),
      .dt_val   (dt_value),
      .dt_en    (dt_en),
      .div2     (dt_div2),
      .drive_ok (drive_ok),
      .on_hi    (on_hi[g]),
      .on_lo    (on_lo[g]),
      .both_req (both[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault <= 1'b0;
    else if (|both)    fault <= 1'b1;
    else if (flag_clr) fault <= 1'b0;
  end

  assign drv_pos = on_hi ^ {N_PH{~act_hi_pos}};
  assign drv_neg = on_lo ^ {N_PH{~act_hi_neg}};
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int N_PH = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_PH-1:0] ph_hi,
  input logic [N_PH-1:0] ph_lo,
  input logic            act_hi_pos,
  input logic            act_hi_neg,
  input logic            mc_mode,
  input logic            out_enable,
  input logic            cutoff_n,
  input logic            flag_clr,
  input logic [N_PH-1:0] drv_pos,
  input logic [N_PH-1:0] drv_neg,
  input logic            fault
);
  logic [N_PH-1:0] pos_act;
  logic [N_PH-1:0] neg_act;
  assign pos_act = ~(drv_pos ^ {N_PH{act_hi_pos}});
  assign neg_act = ~(drv_neg ^ {N_PH{act_hi_neg}});

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pos_act == '0 && neg_act == '0 && !fault));

  assert_off_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos_act & ~$past(ph_hi)) == '0) && ((neg_act & ~$past(ph_lo)) == '0));

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_act & neg_act) == '0);

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !flag_clr) |=> fault);

  assert_cutoff_forces_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_mode && out_enable && !cutoff_n) |=> (pos_act == '0 && neg_act == '0));
endmodule

bind dead_time_gen dtg_checker #(.N_PH(N_PH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ph_hi      (ph_hi),
  .ph_lo      (ph_lo),
  .act_hi_pos (act_hi_pos),
  .act_hi_neg (act_hi_neg),
  .mc_mode    (mc_mode),
  .out_enable (out_enable),
  .cutoff_n   (cutoff_n),
  .flag_clr   (flag_clr),
  .drv_pos    (drv_pos),
  .drv_neg    (drv_neg),
  .fault      (fault)
);

// File: tb/test_dead_time_gen.sv
module test_dead_time_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ph_hi = 3'b000;
  logic [2:0] ph_lo = 3'b000;
  logic [7:0] dt_value = 8'd5;
  logic       dt_div2 = 1'b0;
  logic       dt_en = 1'b1;
  logic       act_hi_pos = 1'b1;
  logic       act_hi_neg = 1'b1;
  logic       mc_mode = 1'b1;
  logic       out_enable = 1'b0;
  logic       cutoff_n = 1'b1;
  logic       flag_clr = 1'b0;
  logic [2:0] drv_pos;
  logic [2:0] drv_neg;
  logic       fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dead_time_gen i_dead_time_gen (
    .clk(clk), .rst_n(rst_n), .ph_hi(ph_hi), .ph_lo(ph_lo),
    .dt_value(dt_value), .dt_div2(dt_div2), .dt_en(dt_en),
    .act_hi_pos(act_hi_pos), .act_hi_neg(act_hi_neg), .mc_mode(mc_mode),
    .out_enable(out_enable), .cutoff_n(cutoff_n), .flag_clr(flag_clr),
    .drv_pos(drv_pos), .drv_neg(drv_neg), .fault(fault)
  );

  function automatic logic [2:0] pos_act();
    return ~(drv_pos ^ {3{act_hi_pos}});
  endfunction
  function automatic logic [2:0] neg_act();
    return ~(drv_neg ^ {3{act_hi_neg}});
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    negs(2);
    chk("R1 drv_pos idle", drv_pos, 3'b000);
    chk("R1 drv_neg idle", drv_neg, 3'b000);
    chk("R1 fault", fault, 0);
    rst_n = 1'b1;
    negs(1);
    out_enable = 1'b1;
    ph_lo = 3'b111;
    negs(20);
    chk("R1 low side after arming", neg_act(), 3'b111);
  endtask

  task automatic t_dead_div1;
    dt_en = 1'b1; dt_div2 = 1'b0; dt_value = 8'd5;
    ph_hi[0] = 1'b1; ph_lo[0] = 1'b0;
    negs(1);
    chk("R5 low side off at once", neg_act(), 3'b110);
    chk("R11 other phases kept", neg_act() & 3'b110, 3'b110);
    negs(5);
    chk("R2 not yet on", pos_act(), 3'b000);
    negs(1);
    chk("R2 on after p+1", pos_act(), 3'b001);
  endtask

  task automatic t_dead_div2;
    dt_div2 = 1'b1; dt_value = 8'd3;
    ph_hi[1] = 1'b1; ph_lo[1] = 1'b0;
    negs(7);
    chk("R3 not yet on", pos_act(), 3'b001);
    negs(1);
    chk("R3 on after 2p+1", pos_act(), 3'b011);
    chk("R11 phase2 low kept", neg_act(), 3'b100);
  endtask

  task automatic t_no_dead;
    dt_en = 1'b0;
    ph_hi[2] = 1'b1; ph_lo[2] = 1'b0;
    negs(1);
    chk("R4 immediate on", pos_act(), 3'b111);
    chk("R4 low off", neg_act(), 3'b000);
  endtask

  task automatic t_polarity;
    act_hi_pos = 1'b0;
    negs(1);
    chk("R6 pos active low", drv_pos, 3'b000);
    chk("R6 neg unchanged", drv_neg, 3'b000);
    act_hi_neg = 1'b0;
    negs(1);
    chk("R6 neg idle high", drv_neg, 3'b111);
    act_hi_pos = 1'b1; act_hi_neg = 1'b1;
    negs(1);
  endtask

  task automatic t_guard;
    dt_en = 1'b1; dt_div2 = 1'b0; dt_value = 8'd2;
    ph_lo[1] = 1'b1;
    negs(3);
    chk("R8 fault not yet", fault, 0);
    negs(1);
    chk("R8 fault set", fault, 1);
    chk("R7 phase1 pos off", pos_act(), 3'b101);
    chk("R7 phase1 neg off", neg_act(), 3'b000);
    ph_lo[1] = 1'b0;
    negs(6);
    chk("R8 fault sticky", fault, 1);
    chk("R7 phase1 back on", pos_act(), 3'b111);
    flag_clr = 1'b1; negs(1); flag_clr = 1'b0;
    chk("R8 fault cleared", fault, 0);
  endtask

  task automatic t_cut_ignored;
    mc_mode = 1'b0; cutoff_n = 1'b0;
    negs(3);
    chk("R9 ignored without mode", pos_act(), 3'b111);
    cutoff_n = 1'b1; mc_mode = 1'b1;
    negs(1);
  endtask

  task automatic t_cutoff;
    cutoff_n = 1'b0;
    negs(1);
    chk("R9 forced off", pos_act(), 3'b000);
    cutoff_n = 1'b1;
    negs(3);
    chk("R10 latched", pos_act(), 3'b000);
    out_enable = 1'b0; negs(1); out_enable = 1'b1;
    negs(3);
    chk("R10 rearm alone not enough", pos_act(), 3'b000);
    flag_clr = 1'b1; negs(1); flag_clr = 1'b0;
    chk("R10 off at clear edge", pos_act(), 3'b000);
    negs(1);
    chk("R10 drives after clear", pos_act(), 3'b111);
  endtask

  initial begin
    t_reset();
    t_dead_div1();
    t_dead_div2();
    t_no_dead();
    t_polarity();
    t_guard();
    t_cut_ignored();
    t_cutoff();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule